// File: doc/BRIEF.md
# Two-Wire Block-Transfer Configuration Register Slave

This block is a serial two-wire bus slave that holds seven 8-bit configuration registers for a clock generator and drives their contents to the clock-control logic. It answers two transfer types only. A block write carries a command byte and a count byte, whose values are discarded, and then data that fills the registers in order from register 0 upward. A block read returns a byte count and then every register in order. No random access is provided. A write always starts at register 0 and may end with a stop after any complete byte.

SCL and SDA are sampled by the system clock through two-flop synchronizers. Start and stop conditions are found as SDA edges while SCL is high. The slave pulls SDA low through an open-drain enable. Some register bits are read-only and show the live level of status pins. Three bits load the frequency-select pins while reset is held, and software may overwrite them later. The slave does not stretch the clock and does not take part in arbitration. It is meant for standard-mode bus rates of 100 kbit/s or less.

Top module: `blk_cfg_slave`

## Requirements
- R1: The slave acknowledges the address byte 0xD2 (write) and 0xD3 (read) by holding SDA low during the ninth clock. It does not acknowledge any other address byte, and it ignores all later bytes until the next start condition.
- R2: In a write, the first two bytes after the address (command and count) are acknowledged, and no register changes because of them.
- R3: Write data byte i (counting from 0) goes to register i. Each data byte is acknowledged. A stop after any complete byte leaves the higher registers unchanged. Register k is presented on regsOut[8k+7:8k].
- R4: A read returns 0x07 first and then registers 0 to 6. The slave goes on only while the master acknowledges, and it releases SDA after a master not-acknowledge.
- R5: After reset the registers are: register 0 = {3'b000, pinLiveA, 1'b0, pinFreqSel as sampled during reset}, register 1 = {pinLiveB, 4'b0000, 3'b111}, register 2 = 0x7F, register 3 = 0xC7, register 4 = 0x3F, register 5 = 0x00, register 6 = 0xFF. A later change on pinFreqSel has no effect.
- R6: Register 0 bit 4 follows pinLiveA and register 1 bit 7 follows pinLiveB, each after two clocks of synchronization. Writes do not change these two bits.
- R7: Register 0 bits 2..0 can be overwritten by a write after their reset capture. Register 0 bits 7..5 and 3 are also writable.
- R8: Register 6 is read-only. Data bytes for register 6 and beyond are acknowledged and discarded.
- R9: The slave changes its SDA drive only while SCL is low.
- R10: Registers change only on the cycle after a completed write data byte. The live bits are the only exception. Reads leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Synchronous active-low reset |
| sclIn | input | 1 | Bus clock level |
| sdaIn | input | 1 | Bus data level |
| sdaDrvLow | output | 1 | Open-drain enable; 1 pulls SDA low |
| pinFreqSel | input | 3 | Frequency-select pins, captured into register 0 during reset |
| pinLiveA | input | 1 | Status pin shown in register 0 bit 4 |
| pinLiveB | input | 1 | Status pin shown in register 1 bit 7 |
| regsOut | output | 56 | All seven registers, register k at bits 8k+7:8k |

## Verification
On every cycle the assertions check four things: SDA drive changes only while SCL is low, write strobes last one cycle, the writable register bits hold their value when there is no write strobe, and register 6 and the two live bits match their rules. The bench scenarios are needed for everything that takes a whole transfer to show. That covers which address bytes are acknowledged, whether the dummy command and count are discarded, which register each data byte lands in, where a stop cuts a write short, the read count and byte order, and the reset capture of the select pins.

// File: rtl/blk_cfg_pkg.sv
package blk_cfg_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_NUM = 7;
  localparam int IDX_W = $clog2(REG_NUM + 3);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int FSEL_W = 3;
  localparam int LIVE_A_REG = 0;
  localparam int LIVE_A_BIT = 4;
  localparam int LIVE_B_REG = 1;
  localparam int LIVE_B_BIT = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } busState_t;

  // strobes from bus control to the register datapath
  typedef struct packed {
    logic              wrEn;
    logic [IDX_W-1:0]  wrIdx;
    logic [BYTE_W-1:0] wrData;
    logic [IDX_W-1:0]  rdIdx;
  } cfgStrobe_t;

  function automatic logic [BYTE_W-1:0] regDefault(input int idx);
    case (idx)
      1:       regDefault = 8'h07;
      2:       regDefault = 8'h7F;
      3:       regDefault = 8'hC7;
      4:       regDefault = 8'h3F;
      6:       regDefault = 8'hFF;
      default: regDefault = 8'h00;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] regWrMask(input int idx);
    case (idx)
      0:          regWrMask = 8'hEF;
      1:          regWrMask = 8'h7F;
      2, 3, 4, 5: regWrMask = 8'hFF;
      default:    regWrMask = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/blk_cfg_ctrl.sv
module blk_cfg_ctrl
  import blk_cfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rdByte,
  output cfgStrobe_t        ctrlStb,
  output logic              sdaDrvLow
);
  localparam logic [CNT_W-1:0] BIT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall, startDet, stopDet;

  busState_t state;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shiftReg, txByte;
  logic [IDX_W-1:0]  byteNum, byteNumInc;
  logic ackDrive, rdMode, mAck, byteFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  assign byteFull   = (bitCnt == BIT_FULL);
  assign byteNumInc = (byteNum == '1) ? byteNum : byteNum + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      shiftReg <= '0;
      byteNum  <= '0;
      ackDrive <= 1'b0;
      rdMode   <= 1'b0;
      txByte   <= '1;
      mAck     <= 1'b0;
    end else if (startDet) begin
      state    <= ST_ADDR;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
    end else if (stopDet) begin
      state    <= ST_IDLE;
      ackDrive <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WR: begin
          if (sclRise && !byteFull) begin
            shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
            bitCnt   <= bitCnt + 1'b1;
          end else if (sclFall && byteFull) begin
            if (state == ST_ADDR) begin
              if (shiftReg[BYTE_W-1:1] == SLAVE_ADDR) begin
                ackDrive <= 1'b1;
                rdMode   <= shiftReg[0];
                byteNum  <= '0;
                state    <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              ackDrive <= 1'b1;
              byteNum  <= byteNumInc;
              state    <= ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            ackDrive <= 1'b0;
            bitCnt   <= '0;
            if (rdMode) begin
              txByte  <= rdByte;
              byteNum <= byteNumInc;
              state   <= ST_RD;
            end else begin
              state <= ST_WR;
            end
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            ackDrive <= 1'b0;
            bitCnt   <= '0;
            state    <= ST_WR;
          end
        end
        ST_RD: begin
          if (sclFall) begin
            if (bitCnt == BIT_LAST) begin
              bitCnt <= '0;
              state  <= ST_RD_ACK;
            end else begin
              bitCnt <= bitCnt + 1'b1;
              txByte <= {txByte[BYTE_W-2:0], 1'b1};
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) begin
            mAck <= ~sdaS;
          end else if (sclFall) begin
            if (mAck) begin
              txByte  <= rdByte;
              byteNum <= byteNumInc;
              state   <= ST_RD;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctrlStb.wrEn   = (state == ST_WR) && sclFall && byteFull && (byteNum >= IDX_W'(2));
    ctrlStb.wrIdx  = byteNum - IDX_W'(2);
    ctrlStb.wrData = shiftReg;
    ctrlStb.rdIdx  = byteNum;
  end

  assign sdaDrvLow = (state == ST_RD) ? ~txByte[BYTE_W-1] : ackDrive;
endmodule

// File: rtl/blk_cfg_regs.sv
module blk_cfg_regs
  import blk_cfg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  cfgStrobe_t               ctrlStb,
  input  logic [FSEL_W-1:0]        pinFreqSel,
  input  logic                     pinLiveA,
  input  logic                     pinLiveB,
  output logic [BYTE_W-1:0]        rdByte,
  output logic [REG_NUM*BYTE_W-1:0] regsOut
);
  logic [1:0] liveASync, liveBSync;
  logic [REG_NUM-1:0][BYTE_W-1:0] stored;
  logic [REG_NUM-1:0][BYTE_W-1:0] view;

  always_ff @(posedge clk) begin
    liveASync <= {liveASync[0], pinLiveA};
    liveBSync <= {liveBSync[0], pinLiveB};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < REG_NUM; k++)
        stored[k] <= regDefault(k) | ((k == 0) ? BYTE_W'(pinFreqSel) : '0);
    end else if (ctrlStb.wrEn) begin
      for (int k = 0; k < REG_NUM; k++)
        if (ctrlStb.wrIdx == IDX_W'(k))
          stored[k] <= (stored[k] & ~regWrMask(k)) | (ctrlStb.wrData & regWrMask(k));
    end
  end

  // live status bits are never written, so their stored copy stays 0
  genvar g;
  generate
    for (g = 0; g < REG_NUM; g++) begin : g_view
      if (g == LIVE_A_REG) begin : g_liveA
        assign view[g] = stored[g] | (BYTE_W'(liveASync[1]) << LIVE_A_BIT);
      end else if (g == LIVE_B_REG) begin : g_liveB
        assign view[g] = stored[g] | (BYTE_W'(liveBSync[1]) << LIVE_B_BIT);
      end else begin : g_plain
        assign view[g] = stored[g];
      end
      assign regsOut[g*BYTE_W +: BYTE_W] = view[g];
    end
  endgenerate

  always_comb begin
    rdByte = '1;
    if (ctrlStb.rdIdx == '0) rdByte = BYTE_W'(REG_NUM);
    for (int k = 0; k < REG_NUM; k++)
      if (ctrlStb.rdIdx == IDX_W'(k + 1)) rdByte = view[k];
  end
endmodule

// File: rtl/blk_cfg_slave.sv
module blk_cfg_slave
  import blk_cfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sclIn,
  input  logic                      sdaIn,
  output logic                      sdaDrvLow,
  input  logic [FSEL_W-1:0]         pinFreqSel,
  input  logic                      pinLiveA,
  input  logic                      pinLiveB,
  output logic [REG_NUM*BYTE_W-1:0] regsOut
);
  cfgStrobe_t ctrlStb;
  logic [BYTE_W-1:0] rdByte;

  blk_cfg_ctrl #(.SLAVE_ADDR(SLAVE_ADDR), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdByte(rdByte), .ctrlStb(ctrlStb), .sdaDrvLow(sdaDrvLow)
  );

  blk_cfg_regs regs_i (
    .clk(clk), .rstN(rstN), .ctrlStb(ctrlStb), .pinFreqSel(pinFreqSel),
    .pinLiveA(pinLiveA), .pinLiveB(pinLiveB), .rdByte(rdByte), .regsOut(regsOut)
  );
endmodule

// File: rtl/blk_cfg_slave_chk.sv
module blk_cfg_slave_chk
  import blk_cfg_pkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic                      sclIn,
  input logic                      sdaDrvLow,
  input logic                      pinLiveA,
  input logic                      pinLiveB,
  input logic                      wrEn,
  input logic [REG_NUM*BYTE_W-1:0] regsOut
);
  function automatic logic [REG_NUM*BYTE_W-1:0] holdMaskCalc();
    logic [REG_NUM*BYTE_W-1:0] m;
    for (int k = 0; k < REG_NUM; k++) m[k*BYTE_W +: BYTE_W] = regWrMask(k);
    return m;
  endfunction
  localparam logic [REG_NUM*BYTE_W-1:0] HOLD_MASK = holdMaskCalc();

  logic [1:0] upCnt;
  always_ff @(posedge clk) begin
    if (!rstN) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 1'b1;
  end

  // R9
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdaDrvLow != $past(sdaDrvLow)) |-> !sclIn);

  // R3
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);

  // R10
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ((regsOut & HOLD_MASK) == ($past(regsOut) & HOLD_MASK)));

  // R8
  ro_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    regsOut[6*BYTE_W +: BYTE_W] == 8'hFF);

  // R6
  live_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 2'd2) |-> (regsOut[LIVE_A_REG*BYTE_W + LIVE_A_BIT] == $past(pinLiveA, 2)
                        && regsOut[LIVE_B_REG*BYTE_W + LIVE_B_BIT] == $past(pinLiveB, 2)));
endmodule

bind blk_cfg_slave blk_cfg_slave_chk chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDrvLow(sdaDrvLow),
  .pinLiveA(pinLiveA), .pinLiveB(pinLiveB), .wrEn(ctrlStb.wrEn), .regsOut(regsOut)
);

// File: tb/blk_cfg_slave_tb_top.sv
module blk_cfg_slave_tb_top;
  localparam int HALF = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic liveA = 1'b1;
  logic liveB = 1'b0;
  logic [2:0] fsel = 3'b101;
  logic sdaDrvLow;
  logic [55:0] regsOut;
  wire sdaBus = sdaM & ~sdaDrvLow;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [7];
  logic [7:0] txData [16];

  always #4 clk = ~clk;

  blk_cfg_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaDrvLow(sdaDrvLow),
    .pinFreqSel(fsel), .pinLiveA(liveA), .pinLiveB(liveB), .regsOut(regsOut)
  );

  function automatic logic [7:0] maskOf(int k);
    if (k == 0) return 8'hEF;
    if (k == 1) return 8'h7F;
    if (k == 6) return 8'h00;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] expView(int k);
    logic [7:0] v;
    v = model[k];
    if (k == 0) v[4] = liveA;
    if (k == 1) v[7] = liveB;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; sclM = 1'b1; waitCyc(HALF);
    sdaM = 1'b0; waitCyc(HALF);
    sclM = 1'b0; waitCyc(HALF / 2);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitCyc(HALF);
    sclM = 1'b1; waitCyc(HALF);
    sdaM = 1'b1; waitCyc(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitCyc(HALF);
      sclM = 1'b1; waitCyc(HALF);
      sclM = 1'b0;
    end
    sdaM = 1'b1; waitCyc(HALF);
    sclM = 1'b1; waitCyc(HALF / 2);
    ack = ~sdaBus;
    waitCyc(HALF / 2);
    sclM = 1'b0;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    logic early;
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitCyc(HALF);
      sclM = 1'b1; waitCyc(HALF / 4);
      early = sdaBus; waitCyc(HALF / 2);
      b[i] = sdaBus;
      chk("R9 sda stable while scl high", 32'(early), 32'(b[i]));
      waitCyc(HALF - HALF / 4 - HALF / 2);
      sclM = 1'b0;
    end
    sdaM = ackIt ? 1'b0 : 1'b1; waitCyc(HALF);
    sclM = 1'b1; waitCyc(HALF);
    sclM = 1'b0; waitCyc(1);
    sdaM = 1'b1;
  endtask

  task automatic checkRegs(input string req);
    for (int k = 0; k < 7; k++)
      chk(req, 32'(regsOut[k*8 +: 8]), 32'(expView(k)));
  endtask

  task automatic writeTxn(input int nData);
    logic ack;
    startCond();
    sendByte(8'hD2, ack);
    chk("R1 write address ack", 32'(ack), 32'd1);
    sendByte(8'($urandom), ack);
    chk("R2 command ack", 32'(ack), 32'd1);
    sendByte(8'($urandom), ack);
    chk("R2 count ack", 32'(ack), 32'd1);
    for (int i = 0; i < nData; i++) begin
      sendByte(txData[i], ack);
      chk(i >= 6 ? "R8 data ack" : "R3 data ack", 32'(ack), 32'd1);
      if (i < 7) model[i] = (model[i] & ~maskOf(i)) | (txData[i] & maskOf(i));
    end
    stopCond();
    waitCyc(4);
  endtask

  task automatic readAll(input string req);
    logic ack;
    logic [7:0] b;
    startCond();
    sendByte(8'hD3, ack);
    chk("R1 read address ack", 32'(ack), 32'd1);
    recvByte(1'b1, b);
    chk("R4 count byte", 32'(b), 32'd7);
    for (int k = 0; k < 7; k++) begin
      recvByte(k != 6, b);
      chk(req, 32'(b), 32'(expView(k)));
    end
    stopCond();
    chk("R4 sda released after nack", 32'(sdaDrvLow), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all-R actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic ack;
    void'($urandom(32'h5EED));
    model[0] = 8'h05; model[1] = 8'h07; model[2] = 8'h7F; model[3] = 8'hC7;
    model[4] = 8'h3F; model[5] = 8'h00; model[6] = 8'hFF;
    waitCyc(6);
    rstN = 1'b1;
    waitCyc(2);
    fsel = 3'b010;
    waitCyc(6);
    checkRegs("R5 reset value");
    chk("R5 select capture", 32'(regsOut[2:0]), 32'd5);

    readAll("R4 read default");

    // dummy bytes only
    writeTxn(0);
    checkRegs("R2 dummy bytes ignored");

    // stop after two data bytes
    txData[0] = 8'hFF; txData[1] = 8'hFF;
    writeTxn(2);
    checkRegs("R3 partial write");
    chk("R7 select overwritten", 32'(regsOut[2:0]), 32'd7);
    chk("R6 live bit kept", 32'(regsOut[15]), 32'(liveB));

    // full write plus extra bytes
    for (int i = 0; i < 10; i++) txData[i] = 8'(8'hA0 + i);
    writeTxn(10);
    checkRegs("R3 full write");
    chk("R8 read-only byte", 32'(regsOut[55:48]), 32'hFF);

    // foreign addresses
    for (int a = 0; a < 2; a++) begin
      startCond();
      sendByte(a == 0 ? 8'hA4 : 8'hD0, ack);
      chk("R1 foreign address nack", 32'(ack), 32'd0);
      sendByte(8'h00, ack);
      chk("R1 later byte ignored", 32'(ack), 32'd0);
      stopCond();
      waitCyc(4);
      checkRegs("R1 no change");
    end

    liveA = 1'b0; liveB = 1'b1;
    waitCyc(6);
    checkRegs("R6 live bits");
    readAll("R6 live readback");
    checkRegs("R10 read leaves registers");

    for (int it = 0; it < 12; it++) begin
      int n;
      n = $urandom_range(0, 10);
      for (int i = 0; i < n; i++) txData[i] = 8'($urandom);
      if (it % 3 == 0) begin
        liveA = 1'($urandom); liveB = 1'($urandom);
      end
      writeTxn(n);
      checkRegs("R3 random write");
      readAll("R4 random readback");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule